// File: doc/BRIEF.md
# Prescaled Modulus Down-Counter with Underflow Flag

This block is a down-counter whose count steps are paced by a selectable clock prescaler. Software writes a load value and a prescaler choice. A load strobe copies the value into the count register. The counter then decrements once per prescaled tick. When it has reached zero, the next tick reloads it from the load value, so the counter produces a periodic underflow event.

Each decrement into zero sets a sticky underflow flag. Software clears the flag with a write-1 to its status bit. In a fast-clear mode, any access to the count register also clears it. The flag, gated by an interrupt enable, drives an interrupt request.

A new prescaler choice does not take effect at once. It stays pending until the next transfer of the load value into the count register, whether by software load or by automatic reload. While the counter is disabled, the count is held at all-ones. This keeps a stale zero from raising the flag when the counter is switched on.

Top module: `mod_down_counter`

## Requirements
- R1: At reset, and on every clock while `cntEnable` is 0, the count is all-ones (16'hFFFF). The flag is 0 after reset, and a load strobe while disabled leaves the count at all-ones.
- R2: While enabled, the count falls by one every N clocks. N is set by the latched prescaler select: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 16.
- R3: Changing `prescSel` without a transfer into the count register leaves the previous division rate in force.
- R4: A prescaled tick that steps the count from 1 to 0 sets `zeroFlag` at the same clock edge.
- R5: A status write with `flagClrData` = 1 clears the flag. `flagClrData` carries bit 7 of the status write, the only writable bit. A status write with it at 0 leaves the flag unchanged.
- R6: The first prescaled tick after the count has reached zero reloads the count from `loadValue`.
- R7: An automatic reload also latches the pending `prescSel`, which sets the rate for the following decrements.
- R8: While `fastClear` is 1, a pulse on `cntAccess` clears the flag. While `fastClear` is 0, the pulse has no effect on the flag.
- R9: `irqReq` equals `zeroFlag` AND `irqEnable`.
- R10: If a flag set and a flag clear fall on the same clock edge, the flag ends up set.
- R11: While enabled, a load strobe copies `loadValue` into the count at the next edge. It also latches the pending `prescSel` and restarts the prescaler phase, so the first decrement comes a full N clocks after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cntEnable | input | 1 | Counter enable |
| prescSel | input | 2 | Pending prescaler select |
| loadValue | input | 16 | Load register contents |
| loadStrobe | input | 1 | Software load pulse |
| flagWrite | input | 1 | Status register write pulse |
| flagClrData | input | 1 | Bit 7 of the status write data (1 clears the flag) |
| cntAccess | input | 1 | Count register read or write pulse |
| fastClear | input | 1 | Fast-clear mode: a count access clears the flag |
| irqEnable | input | 1 | Interrupt enable |
| count | output | 16 | Current count |
| zeroFlag | output | 1 | Sticky underflow flag |
| irqReq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 16-bit count width, so the all-ones preset is exactly 16'hFFFF. All four division rates lie within a few dozen clocks of a load. Small load values such as 1 and 2 reach the zero, reload and flag corner cases within a handful of cycles. The same width lets pending-select checks and phase-restart checks see a rate change as a one-count difference at a precisely known cycle.

// File: rtl/mdc_pkg.sv
`timescale 1ns/1ps
package mdc_pkg;
  localparam int MAX_DIV = 16;
  localparam int PRESC_W = $clog2(MAX_DIV);

  typedef struct packed {
    logic hold;    // force count to all-ones
    logic load;    // software copy of load value
    logic reload;  // automatic copy after zero
    logic dec;     // decrement by one
  } ctlStrobes_t;

  function automatic logic [PRESC_W:0] divOf(input logic [1:0] sel);
    case (sel)
      2'b00:   divOf = (PRESC_W+1)'(1);
      2'b01:   divOf = (PRESC_W+1)'(4);
      2'b10:   divOf = (PRESC_W+1)'(8);
      default: divOf = (PRESC_W+1)'(16);
    endcase
  endfunction
endpackage

// File: rtl/mdc_datapath.sv
`timescale 1ns/1ps
module mdc_datapath
  import mdc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobes_t      strb,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] count,
  output logic             isZero,
  output logic             isOne
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)                        count <= ALL_ONES;
    else if (strb.hold)                count <= ALL_ONES;
    else if (strb.load || strb.reload) count <= loadValue;
    else if (strb.dec)                 count <= count - ONE;
  end

  assign isZero = (count == '0);
  assign isOne  = (count == ONE);

  assert_preset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.hold |=> count == ALL_ONES);

  assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && !strb.hold) |=> count == $past(loadValue));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.dec && !strb.hold && !strb.load && !strb.reload) |=> count == $past(count) - ONE);
endmodule

// File: rtl/mdc_control.sv
`timescale 1ns/1ps
module mdc_control
  import mdc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cntEnable,
  input  logic [1:0]  prescSel,
  input  logic        loadStrobe,
  input  logic        flagWrite,
  input  logic        flagClrData,
  input  logic        cntAccess,
  input  logic        fastClear,
  input  logic        isZero,
  input  logic        isOne,
  output ctlStrobes_t strb,
  output logic        zeroFlag
);
  logic [PRESC_W-1:0] prescPhase;
  logic [1:0]         activeSel;
  logic [PRESC_W:0]   divNow;
  logic               tick;
  logic               setEv;
  logic               clrEv;

  assign divNow = divOf(activeSel);
  assign tick   = cntEnable && ({1'b0, prescPhase} == divNow - 1'b1);

  always_comb begin
    strb.hold   = !cntEnable;
    strb.load   = cntEnable && loadStrobe;
    strb.reload = tick && isZero && !loadStrobe;
    strb.dec    = tick && !isZero && !loadStrobe;
  end

  assign setEv = strb.dec && isOne;
  assign clrEv = (flagWrite && flagClrData) || (fastClear && cntAccess);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prescPhase <= '0;
      activeSel  <= 2'b00;
      zeroFlag   <= 1'b0;
    end else begin
      if (!cntEnable || loadStrobe || tick) prescPhase <= '0;
      else                                  prescPhase <= prescPhase + 1'b1;

      if (loadStrobe || strb.reload) activeSel <= prescSel;

      if (setEv)      zeroFlag <= 1'b1;
      else if (clrEv) zeroFlag <= 1'b0;
    end
  end

  assert_sel_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!loadStrobe && !strb.reload) |=> $stable(activeSel));

  assert_sel_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.reload |=> activeSel == $past(prescSel));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (setEv && clrEv) |=> zeroFlag);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clrEv && !setEv) |=> !zeroFlag);

  assert_fast_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (zeroFlag && !flagWrite && !fastClear) |=> zeroFlag);
endmodule

// File: rtl/mod_down_counter.sv
`timescale 1ns/1ps
module mod_down_counter
  import mdc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntEnable,
  input  logic [1:0]       prescSel,
  input  logic [CNT_W-1:0] loadValue,
  input  logic             loadStrobe,
  input  logic             flagWrite,
  input  logic             flagClrData,
  input  logic             cntAccess,
  input  logic             fastClear,
  input  logic             irqEnable,
  output logic [CNT_W-1:0] count,
  output logic             zeroFlag,
  output logic             irqReq
);
  ctlStrobes_t strb;
  logic        isZero;
  logic        isOne;

  mdc_control ctl_i (
    .clk(clk), .rst_n(rst_n), .cntEnable(cntEnable), .prescSel(prescSel),
    .loadStrobe(loadStrobe), .flagWrite(flagWrite), .flagClrData(flagClrData),
    .cntAccess(cntAccess), .fastClear(fastClear), .isZero(isZero), .isOne(isOne),
    .strb(strb), .zeroFlag(zeroFlag)
  );

  mdc_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .loadValue(loadValue),
    .count(count), .isZero(isZero), .isOne(isOne)
  );

  assign irqReq = zeroFlag && irqEnable;

  assert_flag_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zeroFlag) |-> (count == '0) && ($past(count) == CNT_W'(1)));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irqEnable |-> !irqReq);
endmodule

// File: tb/mod_down_counter_tb.sv
`timescale 1ns/1ps
module mod_down_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cntEnable, loadStrobe, flagWrite, flagClrData;
  logic        cntAccess, fastClear, irqEnable;
  logic [1:0]  prescSel;
  logic [15:0] loadValue;
  logic [15:0] count;
  logic        zeroFlag, irqReq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mod_down_counter #(.CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cntEnable(cntEnable), .prescSel(prescSel),
    .loadValue(loadValue), .loadStrobe(loadStrobe), .flagWrite(flagWrite),
    .flagClrData(flagClrData), .cntAccess(cntAccess), .fastClear(fastClear),
    .irqEnable(irqEnable), .count(count), .zeroFlag(zeroFlag), .irqReq(irqReq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doLoad(input logic [15:0] v, input logic [1:0] s);
    loadValue = v; prescSel = s; loadStrobe = 1'b1;
    step(1);
    loadStrobe = 1'b0;
  endtask

  task automatic statusWrite(input logic b);
    flagWrite = 1'b1; flagClrData = b;
    step(1);
    flagWrite = 1'b0; flagClrData = 1'b0;
  endtask

  task automatic makeFlag();
    cntEnable = 1'b1;
    doLoad(16'd1, 2'b00);
    step(1);
    cntEnable = 1'b0;
    step(1);
  endtask

  task automatic t_reset();
    chk("R1 reset count", count, 16'hFFFF);
    chk("R1 reset flag", {15'd0, zeroFlag}, 16'd0);
    chk("R9 reset irq", {15'd0, irqReq}, 16'd0);
  endtask

  task automatic t_disabled();
    cntEnable = 1'b0;
    doLoad(16'd5, 2'b00);
    chk("R1 load while disabled", count, 16'hFFFF);
    step(3);
    chk("R1 hold while disabled", count, 16'hFFFF);
  endtask

  task automatic t_rates();
    cntEnable = 1'b1;
    doLoad(16'd5, 2'b00); step(3);
    chk("R2 div1", count, 16'd2);
    doLoad(16'd100, 2'b01); step(8);
    chk("R2 div4", count, 16'd98);
    step(3);
    chk("R2 div4 not yet", count, 16'd98);
    step(1);
    chk("R2 div4 next", count, 16'd97);
    doLoad(16'd1000, 2'b10); step(16);
    chk("R2 div8", count, 16'd998);
    doLoad(16'd1000, 2'b11); step(32);
    chk("R2 div16", count, 16'd998);
  endtask

  task automatic t_deferred();
    doLoad(16'd100, 2'b01);
    prescSel = 2'b11;
    step(8);
    chk("R3 old rate kept", count, 16'd98);
    step(4);
    chk("R3 old rate kept later", count, 16'd97);
    doLoad(16'd100, 2'b11); step(16);
    chk("R11 pending select applied", count, 16'd99);
  endtask

  task automatic t_phase();
    doLoad(16'd200, 2'b01); step(2);
    doLoad(16'd200, 2'b01); step(3);
    chk("R11 phase restarted", count, 16'd200);
    step(1);
    chk("R11 first step after full period", count, 16'd199);
  endtask

  task automatic t_zero_reload();
    doLoad(16'd2, 2'b00); step(1);
    chk("R4 count 1", count, 16'd1);
    chk("R4 flag not yet", {15'd0, zeroFlag}, 16'd0);
    step(1);
    chk("R4 count zero", count, 16'd0);
    chk("R4 flag set", {15'd0, zeroFlag}, 16'd1);
    step(1);
    chk("R6 reload", count, 16'd2);
    statusWrite(1'b1);
    chk("R5 cleared", {15'd0, zeroFlag}, 16'd0);
  endtask

  task automatic t_reload_sel();
    doLoad(16'd1, 2'b00);
    loadValue = 16'd50; prescSel = 2'b01;
    step(1);
    chk("R4 flag at zero", {15'd0, zeroFlag}, 16'd1);
    step(1);
    chk("R6 reload new value", count, 16'd50);
    step(3);
    chk("R7 new rate holds", count, 16'd50);
    step(1);
    chk("R7 new rate step", count, 16'd49);
    cntEnable = 1'b0;
    statusWrite(1'b1);
  endtask

  task automatic t_w1c_irq();
    makeFlag();
    chk("R1 disable keeps preset", count, 16'hFFFF);
    statusWrite(1'b0);
    chk("R5 write 0 no effect", {15'd0, zeroFlag}, 16'd1);
    irqEnable = 1'b0; #1;
    chk("R9 irq masked", {15'd0, irqReq}, 16'd0);
    irqEnable = 1'b1; #1;
    chk("R9 irq raised", {15'd0, irqReq}, 16'd1);
    step(1);
    statusWrite(1'b1);
    chk("R5 write 1 clears", {15'd0, zeroFlag}, 16'd0);
    chk("R9 irq drops", {15'd0, irqReq}, 16'd0);
  endtask

  task automatic t_fast_clear();
    makeFlag();
    fastClear = 1'b0; cntAccess = 1'b1; step(1); cntAccess = 1'b0;
    chk("R8 access without mode", {15'd0, zeroFlag}, 16'd1);
    fastClear = 1'b1; cntAccess = 1'b1; step(1); cntAccess = 1'b0;
    chk("R8 access with mode", {15'd0, zeroFlag}, 16'd0);
    fastClear = 1'b0;
  endtask

  task automatic t_set_wins();
    cntEnable = 1'b1;
    doLoad(16'd1, 2'b00);
    statusWrite(1'b1);
    chk("R10 set beats clear", {15'd0, zeroFlag}, 16'd1);
    cntEnable = 1'b0;
    statusWrite(1'b1);
  endtask

  initial begin
    rst_n = 1'b0; cntEnable = 1'b0; loadStrobe = 1'b0; flagWrite = 1'b0;
    flagClrData = 1'b0; cntAccess = 1'b0; fastClear = 1'b0; irqEnable = 1'b1;
    prescSel = 2'b00; loadValue = 16'd0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_disabled();
    t_rates();
    t_deferred();
    t_phase();
    t_zero_reload();
    t_reload_sel();
    t_w1c_irq();
    t_fast_clear();
    t_set_wins();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule